// File: doc/BRIEF.md
# Quantum-Counted Output Delay Element

This block is the timing stage of a logic-element model. A combinational gate function turns a set of input words into an instantaneous result Yc. The stage shows that result on its registered output Y only after a programmable whole number of time quanta has elapsed. A quantum is marked by a single-cycle enable pulse, `qtick`, which the surrounding simulation fabric asserts whenever model time advances by one step.

The stage holds three pieces of state. A current-value register drives Y. A future-value register holds the value that is waiting to appear. A down-counter holds the number of quanta left before that value appears. Only one event can be pending at a time. A fresh change of Yc replaces the waiting value and restarts the count, so pulses shorter than the delay are swallowed. This is inertial behaviour. A Yc that returns to the value already on Y withdraws the pending event.

Top module: `qdly_top`

## Requirements
- R1: Yc is formed from the NIN input words packed in `in_vec`, with word k at bits [k*W+W-1 : k*W]. The `fn_sel` encoding is: 2'b00 passes word 0, 2'b01 is the bitwise AND of all words, 2'b10 is the bitwise OR of all words, and 2'b11 is the bitwise XOR of all words.
- R2: While `rst` is high at a clock edge, Y, the waiting value, the pending state and the counter are all cleared to 0 at that edge.
- R3: In a cycle where Yc differs both from the pending target and from Y, the stage schedules an event. The pending target is the waiting value if an event is pending, and Y otherwise. Scheduling stores Yc as the waiting value and loads the counter with `dly` sampled in that same cycle. Y keeps its old value until the event expires.
- R4: The counter of a pending event advances only in cycles where `qtick` is high. Cycles without `qtick` leave the remaining time unchanged.
- R5: For a `dly` of D ≥ 1 with no further Yc change, Y takes the waiting value at the edge of the D-th `qtick` cycle after the scheduling cycle.
- R6: A `dly` of 0 behaves like 1: Y takes the waiting value at the edge of the first `qtick` cycle after the scheduling cycle.
- R7: If Yc changes to a third value before expiry, the waiting value is overwritten and the count restarts from the `dly` of that cycle. The earlier waiting value never reaches Y.
- R8: If Yc returns to the value on Y before expiry, the pending event is cancelled, the counter is cleared, and Y does not change.
- R9: A `qtick` in the same cycle as a schedule or a cancel is not counted toward the new event.
- R10: Y changes only at the edge that ends a cycle in which `qtick` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qtick | input | 1 | One-cycle pulse marking one time quantum |
| fn_sel | input | 2 | Gate function select (see R1) |
| in_vec | input | NIN*W | Packed gate input words |
| dly | input | CW | Delay in quanta, sampled when an event is scheduled |
| y | output | W | Delayed output value |

## Verification
The main function is driven with a dense `qtick` pattern (every cycle), a sparse pattern (every fourth cycle) and an irregular pseudo-random pattern. The dense pattern separates a count from the scheduling cycle from a count from the next tick. The sparse pattern shows that only ticks advance time. The random pattern exposes ordering faults between ticks and changes. Directed sequences cover the following cases:
- a change left to expire, which measures the exact delay for several values of `dly`, including 0 and 1;
- a second different change before expiry, which separates inertial overwriting from first-value-wins;
- a return to the current Y before expiry, which separates cancelling from letting a stale event fire.

A cycle-level behavioural model is compared against Y on every clock. The gate function is exercised in each of the four select codes with varied input words.

// File: rtl/qdly_pkg.sv
package qdly_pkg;

    typedef enum logic [1:0] {
        FN_PASS = 2'b00,
        FN_AND  = 2'b01,
        FN_OR   = 2'b10,
        FN_XOR  = 2'b11
    } fn_e;

    // one-cycle decision for the delay state
    typedef struct packed {
        logic sched;   // store Yc as waiting value, load counter
        logic cancel;  // drop the waiting value, clear counter
        logic expire;  // copy waiting value to the output
    } evt_t;

    function automatic logic at_most_one(input evt_t e);
        return (32'(e.sched) + 32'(e.cancel) + 32'(e.expire)) <= 32'd1;
    endfunction

endpackage

// File: rtl/qdly_gate.sv
module qdly_gate
    import qdly_pkg::*;
#(
    parameter int W   = 4,
    parameter int NIN = 3
) (
    input  logic [NIN*W-1:0] in_vec,
    input  logic [1:0]       fn_sel,
    output logic [W-1:0]     yc
);
    logic [W-1:0] and_c [NIN];
    logic [W-1:0] or_c  [NIN];
    logic [W-1:0] xor_c [NIN];

    assign and_c[0] = in_vec[W-1:0];
    assign or_c[0]  = in_vec[W-1:0];
    assign xor_c[0] = in_vec[W-1:0];

    generate
        for (genvar k = 1; k < NIN; k++) begin : g_chain
            assign and_c[k] = and_c[k-1] & in_vec[k*W +: W];
            assign or_c[k]  = or_c[k-1]  | in_vec[k*W +: W];
            assign xor_c[k] = xor_c[k-1] ^ in_vec[k*W +: W];
        end
    endgenerate

    always_comb begin
        unique case (fn_e'(fn_sel))
            FN_AND:  yc = and_c[NIN-1];
            FN_OR:   yc = or_c[NIN-1];
            FN_XOR:  yc = xor_c[NIN-1];
            default: yc = in_vec[W-1:0];
        endcase
    end
endmodule

// File: rtl/qdly_ctrl.sv
module qdly_ctrl
    import qdly_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] yc,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] fut,
    input  logic         pend,
    input  logic         qtick,
    input  logic         last,
    output evt_t         ev
);
    logic [W-1:0] target;
    logic         moved;

    always_comb begin
        target    = pend ? fut : cur;
        moved     = (yc != target);
        ev.cancel = moved && pend && (yc == cur);
        ev.sched  = moved && !ev.cancel;
        ev.expire = !moved && pend && qtick && last;
    end
endmodule

// File: rtl/qdly_cnt.sv
module qdly_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          clr,
    input  logic          dec,
    input  logic [CW-1:0] dly,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= dly;
        else if (clr)  cnt <= '0;
        else if (dec)  cnt <= cnt - ONE;
    end

    assign last = (cnt <= ONE);

    // R3
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(dly));

    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !clr) |=> cnt == $past(cnt) - ONE);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr && !dec) |=> $stable(cnt));
endmodule

// File: rtl/qdly_vals.sv
module qdly_vals
    import qdly_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] yc,
    input  evt_t         ev,
    output logic [W-1:0] cur,
    output logic [W-1:0] fut,
    output logic         pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            fut  <= '0;
            pend <= 1'b0;
        end else if (ev.sched) begin
            fut  <= yc;
            pend <= 1'b1;
        end else if (ev.cancel) begin
            fut  <= cur;
            pend <= 1'b0;
        end else if (ev.expire) begin
            cur  <= fut;
            pend <= 1'b0;
        end
    end

    // R3
    pend_distinct_chk: assert property (@(posedge clk) disable iff (rst)
        pend |-> fut != cur);

    // R8
    cancel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ev.cancel |=> $stable(cur) && !pend);
endmodule

// File: rtl/qdly_top.sv
module qdly_top
    import qdly_pkg::*;
#(
    parameter int W   = 4,
    parameter int NIN = 3,
    parameter int CW  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qtick,
    input  logic [1:0]       fn_sel,
    input  logic [NIN*W-1:0] in_vec,
    input  logic [CW-1:0]    dly,
    output logic [W-1:0]     y
);
    logic [W-1:0]  yc, cur, fut;
    logic          pend, last;
    logic [CW-1:0] cnt;
    evt_t          ev;

    qdly_gate #(.W(W), .NIN(NIN)) gate_i (
        .in_vec(in_vec), .fn_sel(fn_sel), .yc(yc)
    );

    qdly_ctrl #(.W(W)) ctrl_i (
        .yc(yc), .cur(cur), .fut(fut), .pend(pend),
        .qtick(qtick), .last(last), .ev(ev)
    );

    qdly_vals #(.W(W)) vals_i (
        .clk(clk), .rst(rst), .yc(yc), .ev(ev),
        .cur(cur), .fut(fut), .pend(pend)
    );

    qdly_cnt #(.CW(CW)) cnt_i (
        .clk(clk), .rst(rst),
        .load(ev.sched), .clr(ev.cancel | ev.expire),
        .dec(qtick && pend && !last && !ev.sched && !ev.cancel),
        .dly(dly), .cnt(cnt), .last(last)
    );

    assign y = cur;

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (y == '0) && (cnt == '0) && !pend);

    // R10
    y_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(y) |-> $past(qtick));

    // R8
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        !pend |-> cnt == '0);

    // R9
    one_action_chk: assert property (@(posedge clk) disable iff (rst)
        at_most_one(ev));
endmodule

// File: tb/qdly_top_tb.sv
module qdly_top_tb_top;
    localparam int W   = 4;
    localparam int NIN = 3;
    localparam int CW  = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             qtick;
    logic [1:0]       fn_sel;
    logic [NIN*W-1:0] in_vec;
    logic [CW-1:0]    dly;
    logic [W-1:0]     y;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    int m_cur, m_fut, m_cnt;
    bit m_pend;

    always #2.5 clk = ~clk;

    qdly_top #(.W(W), .NIN(NIN), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .qtick(qtick), .fn_sel(fn_sel),
        .in_vec(in_vec), .dly(dly), .y(y)
    );

    function automatic int word(input int k);
        return int'(in_vec[k*W +: W]);
    endfunction

    function automatic int model_yc();
        int r = word(0);
        for (int k = 1; k < NIN; k++) begin
            case (fn_sel)
                2'b01: r = r & word(k);
                2'b10: r = r | word(k);
                2'b11: r = r ^ word(k);
                default: r = r;
            endcase
        end
        return r;
    endfunction

    // advance the reference by one clock with the inputs now applied, then compare
    task automatic step(input string req);
        int v = model_yc();
        int tgt = m_pend ? m_fut : m_cur;
        if (rst) begin
            m_cur = 0; m_fut = 0; m_cnt = 0; m_pend = 0;
        end else if (v != tgt) begin
            if (m_pend && v == m_cur) begin
                m_pend = 0; m_cnt = 0; m_fut = m_cur;
            end else begin
                m_fut = v; m_pend = 1; m_cnt = int'(dly);
            end
        end else if (m_pend && qtick) begin
            if (m_cnt <= 1) begin
                m_cur = m_fut; m_pend = 0; m_cnt = 0;
            end else m_cnt = m_cnt - 1;
        end
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (int'(y) != m_cur) begin
            failures++;
            $display("FAIL %s y=%0h expected=%0h", req, y, m_cur);
        end
    endtask

    task automatic set_val(input int v);
        fn_sel = 2'b00;
        in_vec = '0;
        in_vec[W-1:0] = W'(v);
    endtask

    // run n cycles with a tick every 'per' cycles
    task automatic run(input int n, input int per, input string req);
        for (int i = 0; i < n; i++) begin
            qtick = (i % per) == (per - 1);
            step(req);
        end
        qtick = 1'b0;
    endtask

    task automatic expect_y(input int v, input string req);
        checks++;
        if (int'(y) != v) begin
            failures++;
            $display("FAIL %s y=%0h expected=%0h", req, y, v);
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog y=%0h expected=finish", y);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; qtick = 1'b1; fn_sel = 2'b11; in_vec = '1; dly = 8'd3;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step("R2");
        expect_y(0, "R2 reset value");
        rst = 1'b0; qtick = 1'b0;

        // R3/R5: delay 3 with a tick every cycle (R9: tick in scheduling cycle)
        dly = 8'd3; set_val(5); qtick = 1'b1;
        step("R9");
        step("R3"); step("R3");
        expect_y(0, "R3 held before expiry");
        step("R5");
        expect_y(5, "R5 after third tick");
        run(3, 1, "R5");

        // R4: sparse ticks, delay 2
        dly = 8'd2; set_val(9);
        run(12, 4, "R4");
        expect_y(9, "R4 after two sparse ticks");

        // R6: delay 0 and 1 expire on the first tick
        dly = 8'd0; set_val(3); qtick = 1'b0;
        step("R6"); step("R6");
        expect_y(9, "R6 waits for a tick");
        qtick = 1'b1; step("R6"); qtick = 1'b0;
        expect_y(3, "R6 first tick");
        dly = 8'd1; set_val(6);
        run(4, 2, "R6");
        expect_y(6, "R6 delay one");

        // R7: overwrite before expiry
        dly = 8'd4; set_val(1);
        run(3, 1, "R7");
        set_val(2);
        run(3, 1, "R7");
        expect_y(6, "R7 first value swallowed");
        run(3, 1, "R7");
        expect_y(2, "R7 second value shown");

        // R8: return to current value cancels
        dly = 8'd3; set_val(7);
        run(2, 1, "R8");
        set_val(2);
        run(8, 1, "R8");
        expect_y(2, "R8 cancelled event");

        // R1: gate functions
        dly = 8'd1;
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 6; t++) begin
                fn_sel = 2'(f);
                in_vec = 12'($urandom_range(0, 4095));
                run(3, 1, "R1");
                expect_y(model_yc(), "R1 gate result");
            end
        end

        // R10: irregular ticks and changes
        for (int i = 0; i < 3000; i++) begin
            qtick  = ($urandom_range(0, 2) == 0);
            fn_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0) in_vec = 12'($urandom_range(0, 4095));
            dly    = 8'($urandom_range(0, 5));
            step("R10");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule